// File: doc/BRIEF.md
# Fence Slot Allocator

This block looks after a small pool of fence slots. Each slot can be bound to one object ID. A client sends one command at a time: get, put, pin or unpin. A get returns a slot for the object. That slot is either the binding the object already holds, a free slot, or a slot taken from another object. The block also tells the client when a slot must be reprogrammed and when an earlier owner has lost its fence.

Each slot keeps an owner, a pin count and an age. The age gives the least-recently-used order among bound slots. Before a slot is taken from its owner, the block raises a wait request that names that owner. It holds the request until the outside logic acknowledges that all accesses through the old fence have drained. New commands are refused while that request is open.

Top module: `fence_alloc`

## Requirements
- R1: A tiled get (`cmd_tiled_i`=1) for an object with no slot takes the lowest-numbered unbound slot. The response is status OK (0) with `rsp_bound_o`=1 and that slot, and in the same cycle `prog_valid_o`=1, `prog_en_o`=1 and `prog_slot_o` equal to that slot.
- R2: If no slot is unbound, a tiled get picks the unpinned bound slot that has gone longest without use.
  - It raises `wait_req_o` with `wait_id_o` set to the old owner and holds it until `wait_ack_i`.
  - On the ack it responds OK with that slot.
  - In the same cycle it pulses `lost_valid_o` with `lost_id_o` set to the old owner, and reprograms the slot (`prog_en_o`=1).
- R3: If every slot is bound and pinned, a tiled get from an object with no slot changes nothing and causes no reprogramming. It responds RETRY (2) when `pend_release_i`=1 and DEADLOCK (3) when `pend_release_i`=0.
- R4: A get with `cmd_dirty_i`=0 from an object that already holds a slot returns that slot with status OK and no reprogramming. The slot becomes the most recently used one.
- R5: A get with `cmd_dirty_i`=1 from an object that holds a slot reprograms that slot.
  - When tiled: `prog_en_o`=1, and the slot stays bound and becomes the most recently used one.
  - When untiled: `prog_en_o`=0, the slot is released, and `rsp_bound_o`=0.
- R6: An untiled get from an object with no slot responds OK with `rsp_bound_o`=0 and does not reprogram anything.
- R7: Put behaves as follows.
  - On a slot with a nonzero pin count: responds BUSY (1) and leaves the binding in place.
  - On an unpinned slot: responds OK with `rsp_bound_o`=0, reprograms the slot with `prog_en_o`=0, and frees the slot for a later get.
  - From an object with no slot: responds OK and does nothing.
- R8: Pin adds one to the slot's pin count and unpin subtracts one.
  - Both respond OK, with `rsp_bound_o` showing whether the object holds a slot.
  - An unpin at count zero, or a pin at the count's maximum, responds PINERR (4) and leaves the count unchanged.
- R9: A response appears in the cycle after a command is accepted, or in the cycle after a wait ack. `cmd_ready_o` is low while `wait_req_o` is high.
- R10: After reset every slot is unbound, `cmd_ready_o`=1, and `rsp_valid_o`, `wait_req_o`, `prog_valid_o` and `lost_valid_o` are 0.

Command codes on `cmd_op_i`: GET=0, PUT=1, PIN=2, UNPIN=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 2 | Command code |
| cmd_id_i | input | ID_W | Object ID |
| cmd_tiled_i | input | 1 | Object needs a fence |
| cmd_dirty_i | input | 1 | Object's fence parameters changed |
| pend_release_i | input | 1 | A pin release is pending elsewhere |
| wait_req_o | output | 1 | Drain request before a slot is taken |
| wait_id_o | output | ID_W | Owner whose accesses must drain |
| wait_ack_i | input | 1 | Drain complete |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_status_o | output | 3 | Response status code |
| rsp_bound_o | output | 1 | Object holds a slot after the command |
| rsp_slot_o | output | SLOT_W | Slot index |
| prog_valid_o | output | 1 | Slot must be reprogrammed |
| prog_en_o | output | 1 | 1: program for owner, 0: clear |
| prog_slot_o | output | SLOT_W | Slot to reprogram |
| lost_valid_o | output | 1 | An owner lost its fence |
| lost_id_o | output | ID_W | ID of that owner |

## Verification
The bench touches one object between filling the pool and taking a slot. A design that ignored that use would pick the wrong victim slot.

It pins all slots and checks both failure codes. A design that returned the wrong code, or that took a pinned slot anyway, is caught.

It unpins twice and then forces a steal. If a zero count wrapped around to its maximum, that slot would stay pinned and the get would report DEADLOCK instead of taking it.

Put on a pinned slot, dirty gets of both kinds, and the pin-count ceiling are each checked. Each check looks at the responses and at the reprogramming outputs.

// File: rtl/fence_alloc_pkg.sv
package fence_alloc_pkg;
  typedef enum logic [1:0] {OP_GET = 2'd0, OP_PUT = 2'd1, OP_PIN = 2'd2, OP_UNPIN = 2'd3} op_e;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_BUSY = 3'd1, ST_RETRY = 3'd2, ST_DEADLOCK = 3'd3, ST_PINERR = 3'd4
  } status_e;
  typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} state_e;
endpackage

// File: rtl/fence_slot_search.sv
module fence_slot_search #(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 8,
  parameter int PIN_W     = 4,
  parameter int SLOT_W    = 2,
  parameter int AGE_W     = 2
) (
  input  logic [NUM_SLOTS-1:0]            vld_i,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0]  id_i,
  input  logic [NUM_SLOTS-1:0][PIN_W-1:0] pin_i,
  input  logic [NUM_SLOTS-1:0][AGE_W-1:0] age_i,
  input  logic [ID_W-1:0]                 key_i,
  output logic                            hit_o,
  output logic [SLOT_W-1:0]               hit_slot_o,
  output logic                            free_o,
  output logic [SLOT_W-1:0]               free_slot_o,
  output logic                            vict_o,
  output logic [SLOT_W-1:0]               vict_slot_o
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    hit_o = 1'b0;  hit_slot_o = '0;
    free_o = 1'b0; free_slot_o = '0;
    vict_o = 1'b0; vict_slot_o = '0;
    best_age = '0;
    // downward scan so the lowest free index wins
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_o = 1'b1;
        free_slot_o = SLOT_W'(i);
      end
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (vld_i[i] && id_i[i] == key_i) begin
        hit_o = 1'b1;
        hit_slot_o = SLOT_W'(i);
      end
    end
    // bound ages are distinct, so the oldest unpinned slot is unique
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (vld_i[i] && pin_i[i] == '0 && (!vict_o || age_i[i] > best_age)) begin
        vict_o = 1'b1;
        vict_slot_o = SLOT_W'(i);
        best_age = age_i[i];
      end
    end
  end
endmodule

// File: rtl/fence_lru_age.sv
module fence_lru_age #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int AGE_W     = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SLOTS-1:0]            bound_i,
  input  logic                            touch_i,
  input  logic [SLOT_W-1:0]               touch_slot_i,
  input  logic                            drop_i,
  input  logic [SLOT_W-1:0]               drop_slot_i,
  output logic [NUM_SLOTS-1:0][AGE_W-1:0] age_o
);
  logic [NUM_SLOTS-1:0][AGE_W-1:0] age_q;
  logic                            touch_was_bound;
  logic [AGE_W-1:0]                touch_age, drop_age;

  assign touch_was_bound = bound_i[touch_slot_i];
  assign touch_age       = age_q[touch_slot_i];
  assign drop_age        = age_q[drop_slot_i];
  assign age_o           = age_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= '0;
      end else if (touch_i) begin
        if (touch_slot_i == SLOT_W'(g))
          age_q[g] <= '0;
        else if (bound_i[g] && (!touch_was_bound || age_q[g] < touch_age))
          age_q[g] <= age_q[g] + 1'b1;
      end else if (drop_i) begin
        // keep ages compact: slots older than the dropped one close the gap
        if (bound_i[g] && drop_slot_i != SLOT_W'(g) && age_q[g] > drop_age)
          age_q[g] <= age_q[g] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fence_alloc.sv
module fence_alloc
  import fence_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 8,
  parameter int PIN_W     = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic              cmd_tiled_i,
  input  logic              cmd_dirty_i,
  input  logic              pend_release_i,
  output logic              wait_req_o,
  output logic [ID_W-1:0]   wait_id_o,
  input  logic              wait_ack_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_status_o,
  output logic              rsp_bound_o,
  output logic [SLOT_W-1:0] rsp_slot_o,
  output logic              prog_valid_o,
  output logic              prog_en_o,
  output logic [SLOT_W-1:0] prog_slot_o,
  output logic              lost_valid_o,
  output logic [ID_W-1:0]   lost_id_o
);
  localparam int AGE_W = SLOT_W;
  localparam logic [PIN_W-1:0] PIN_MAX = '1;

  state_e                          state_q, state_d;
  logic [NUM_SLOTS-1:0]            vld_q;
  logic [NUM_SLOTS-1:0][ID_W-1:0]  id_q;
  logic [NUM_SLOTS-1:0][PIN_W-1:0] pin_q;
  logic [NUM_SLOTS-1:0][AGE_W-1:0] age;
  logic [ID_W-1:0]                 new_id_q;
  logic [SLOT_W-1:0]               vict_q, vict_d;

  logic hit, free, vict;
  logic [SLOT_W-1:0] hit_slot, free_slot, vict_slot;

  logic touch, drop, bind_en, pin_inc, pin_dec;
  logic [SLOT_W-1:0] touch_slot, drop_slot, bind_slot, pin_slot;
  logic [ID_W-1:0] bind_id;
  logic accept;
  logic rsp_v, rsp_b, prog_v, prog_e, lost_v;
  status_e rsp_s;
  logic [SLOT_W-1:0] rsp_sl, prog_sl;
  logic [ID_W-1:0] lost_id;

  fence_slot_search #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .PIN_W(PIN_W), .SLOT_W(SLOT_W), .AGE_W(AGE_W)
  ) u_search (
    .vld_i(vld_q), .id_i(id_q), .pin_i(pin_q), .age_i(age), .key_i(cmd_id_i),
    .hit_o(hit), .hit_slot_o(hit_slot), .free_o(free), .free_slot_o(free_slot),
    .vict_o(vict), .vict_slot_o(vict_slot)
  );

  fence_lru_age #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .AGE_W(AGE_W)) u_lru (
    .clk_i, .rst_ni, .bound_i(vld_q),
    .touch_i(touch), .touch_slot_i(touch_slot),
    .drop_i(drop), .drop_slot_i(drop_slot), .age_o(age)
  );

  assign accept      = cmd_valid_i && state_q == S_IDLE;
  assign cmd_ready_o = state_q == S_IDLE;
  assign wait_req_o  = state_q == S_WAIT;
  assign wait_id_o   = id_q[vict_q];

  always_comb begin
    state_d = state_q; vict_d = vict_q;
    touch = 1'b0; touch_slot = '0; drop = 1'b0; drop_slot = '0;
    bind_en = 1'b0; bind_slot = '0; bind_id = cmd_id_i;
    pin_inc = 1'b0; pin_dec = 1'b0; pin_slot = hit_slot;
    rsp_v = 1'b0; rsp_s = ST_OK; rsp_b = 1'b0; rsp_sl = '0;
    prog_v = 1'b0; prog_e = 1'b0; prog_sl = '0;
    lost_v = 1'b0; lost_id = '0;
    if (state_q == S_WAIT) begin
      if (wait_ack_i) begin
        state_d = S_IDLE;
        bind_en = 1'b1; bind_slot = vict_q; bind_id = new_id_q;
        touch = 1'b1; touch_slot = vict_q;
        rsp_v = 1'b1; rsp_b = 1'b1; rsp_sl = vict_q;
        prog_v = 1'b1; prog_e = 1'b1; prog_sl = vict_q;
        lost_v = 1'b1; lost_id = id_q[vict_q];
      end
    end else if (accept) begin
      rsp_v = 1'b1;
      unique case (op_e'(cmd_op_i))
        OP_GET: begin
          if (hit) begin
            if (cmd_dirty_i && !cmd_tiled_i) begin
              drop = 1'b1; drop_slot = hit_slot;
              prog_v = 1'b1; prog_sl = hit_slot;
            end else begin
              touch = 1'b1; touch_slot = hit_slot;
              rsp_b = 1'b1; rsp_sl = hit_slot;
              prog_v = cmd_dirty_i; prog_e = 1'b1; prog_sl = hit_slot;
            end
          end else if (cmd_tiled_i) begin
            if (free) begin
              bind_en = 1'b1; bind_slot = free_slot;
              touch = 1'b1; touch_slot = free_slot;
              rsp_b = 1'b1; rsp_sl = free_slot;
              prog_v = 1'b1; prog_e = 1'b1; prog_sl = free_slot;
            end else if (vict) begin
              rsp_v = 1'b0;
              state_d = S_WAIT; vict_d = vict_slot;
            end else begin
              rsp_s = pend_release_i ? ST_RETRY : ST_DEADLOCK;
            end
          end
        end
        OP_PUT: begin
          if (hit) begin
            if (pin_q[hit_slot] != '0) begin
              rsp_s = ST_BUSY; rsp_b = 1'b1; rsp_sl = hit_slot;
            end else begin
              drop = 1'b1; drop_slot = hit_slot;
              prog_v = 1'b1; prog_sl = hit_slot;
            end
          end
        end
        OP_PIN: begin
          if (hit) begin
            rsp_b = 1'b1; rsp_sl = hit_slot;
            if (pin_q[hit_slot] == PIN_MAX) rsp_s = ST_PINERR;
            else pin_inc = 1'b1;
          end
        end
        default: begin
          if (hit) begin
            rsp_b = 1'b1; rsp_sl = hit_slot;
            if (pin_q[hit_slot] == '0) rsp_s = ST_PINERR;
            else pin_dec = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; vict_q <= '0; new_id_q <= '0;
      vld_q <= '0; id_q <= '0; pin_q <= '0;
      rsp_valid_o <= 1'b0; rsp_status_o <= '0; rsp_bound_o <= 1'b0; rsp_slot_o <= '0;
      prog_valid_o <= 1'b0; prog_en_o <= 1'b0; prog_slot_o <= '0;
      lost_valid_o <= 1'b0; lost_id_o <= '0;
    end else begin
      state_q <= state_d; vict_q <= vict_d;
      if (accept) new_id_q <= cmd_id_i;
      if (bind_en) begin
        vld_q[bind_slot] <= 1'b1; id_q[bind_slot] <= bind_id; pin_q[bind_slot] <= '0;
      end
      if (drop) begin
        vld_q[drop_slot] <= 1'b0; pin_q[drop_slot] <= '0;
      end
      if (pin_inc) pin_q[pin_slot] <= pin_q[pin_slot] + 1'b1;
      if (pin_dec) pin_q[pin_slot] <= pin_q[pin_slot] - 1'b1;
      rsp_valid_o <= rsp_v; rsp_status_o <= rsp_s; rsp_bound_o <= rsp_b; rsp_slot_o <= rsp_sl;
      prog_valid_o <= prog_v; prog_en_o <= prog_e; prog_slot_o <= prog_sl;
      lost_valid_o <= lost_v; lost_id_o <= lost_id;
    end
  end
endmodule

// File: rtl/fence_alloc_chk.sv
module fence_alloc_chk #(
  parameter int SLOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              wait_req_o,
  input logic              wait_ack_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_status_o,
  input logic              rsp_bound_o,
  input logic [SLOT_W-1:0] rsp_slot_o,
  input logic              prog_valid_o,
  input logic              prog_en_o,
  input logic [SLOT_W-1:0] prog_slot_o,
  input logic              lost_valid_o
);
  p_wait_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_o |-> !cmd_ready_o);
  p_wait_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_o && !wait_ack_i |=> wait_req_o);
  p_steal_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_req_o) |-> rsp_valid_o && lost_valid_o);
  p_lost_prog_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_valid_o |-> prog_valid_o && prog_en_o && rsp_valid_o && rsp_bound_o);
  p_fail_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_status_o == 3'd2 || rsp_status_o == 3'd3) |-> !prog_valid_o && !rsp_bound_o);
  p_busy_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o == 3'd1 |-> !prog_valid_o && rsp_bound_o);
  p_prog_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o && prog_en_o |-> rsp_valid_o && rsp_bound_o && rsp_slot_o == prog_slot_o);
endmodule

bind fence_alloc fence_alloc_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .wait_req_o(wait_req_o),
  .wait_ack_i(wait_ack_i), .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o),
  .rsp_bound_o(rsp_bound_o), .rsp_slot_o(rsp_slot_o), .prog_valid_o(prog_valid_o),
  .prog_en_o(prog_en_o), .prog_slot_o(prog_slot_o), .lost_valid_o(lost_valid_o)
);

// File: tb/fence_alloc_test.sv
module fence_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] GET = 2'd0, PUT = 2'd1, PIN = 2'd2, UNPIN = 2'd3;
  localparam int OK = 0, BUSY = 1, RETRY = 2, DEADLOCK = 3, PINERR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_tiled = 1'b0, cmd_dirty = 1'b0, pend = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_id = '0, wait_id, lost_id;
  logic wait_req, wait_ack = 1'b0;
  logic rsp_valid, rsp_bound, prog_valid, prog_en, lost_valid;
  logic [2:0] rsp_status;
  logic [1:0] rsp_slot, prog_slot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fence_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_id_i(cmd_id), .cmd_tiled_i(cmd_tiled), .cmd_dirty_i(cmd_dirty),
    .pend_release_i(pend), .wait_req_o(wait_req), .wait_id_o(wait_id), .wait_ack_i(wait_ack),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_bound_o(rsp_bound),
    .rsp_slot_o(rsp_slot), .prog_valid_o(prog_valid), .prog_en_o(prog_en),
    .prog_slot_o(prog_slot), .lost_valid_o(lost_valid), .lost_id_o(lost_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] id, input logic tiled, input logic dirty);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_tiled = tiled; cmd_dirty = dirty;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic exp_rsp(input string req, input int st, input int bound, input int slot);
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " status"}, int'(rsp_status), st);
    chk({req, " bound"}, int'(rsp_bound), bound);
    if (bound != 0) chk({req, " slot"}, int'(rsp_slot), slot);
  endtask

  task automatic exp_prog(input string req, input int v, input int en, input int slot);
    chk({req, " prog_valid"}, int'(prog_valid), v);
    if (v != 0) begin
      chk({req, " prog_en"}, int'(prog_en), en);
      chk({req, " prog_slot"}, int'(prog_slot), slot);
    end
  endtask

  task automatic get_new(input string req, input logic [7:0] id, input int slot);
    cmd(GET, id, 1'b1, 1'b0);
    exp_rsp(req, OK, 1, slot);
    exp_prog(req, 1, 1, slot);
  endtask

  task automatic steal(input string req, input logic [7:0] id, input logic [7:0] old, input int slot);
    cmd(GET, id, 1'b1, 1'b0);
    chk({req, " no early rsp"}, int'(rsp_valid), 0);
    chk({req, " wait_req"}, int'(wait_req), 1);
    chk({req, " wait_id"}, int'(wait_id), int'(old));
    chk({req, " ready low"}, int'(cmd_ready), 0);
    @(posedge clk); @(negedge clk);
    chk({req, " wait held"}, int'(wait_req), 1);
    wait_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    wait_ack = 1'b0;
    exp_rsp(req, OK, 1, slot);
    exp_prog(req, 1, 1, slot);
    chk({req, " lost_valid"}, int'(lost_valid), 1);
    chk({req, " lost_id"}, int'(lost_id), int'(old));
    chk({req, " ready back"}, int'(cmd_ready), 1);
  endtask

  task automatic t_reset();
    chk("R10 ready", int'(cmd_ready), 1);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 wait_req", int'(wait_req), 0);
    chk("R10 prog_valid", int'(prog_valid), 0);
    chk("R10 lost_valid", int'(lost_valid), 0);
  endtask

  task automatic t_fill();
    get_new("R1 fill a", 8'd10, 0);
    get_new("R1 fill b", 8'd11, 1);
    get_new("R1 fill c", 8'd12, 2);
    get_new("R1 fill d", 8'd13, 3);
  endtask

  task automatic t_touch();
    cmd(GET, 8'd11, 1'b1, 1'b0);
    exp_rsp("R4 clean hit", OK, 1, 1);
    exp_prog("R4 clean hit", 0, 0, 0);
  endtask

  task automatic t_steal_lru();
    cmd(PIN, 8'd10, 1'b0, 1'b0);
    exp_rsp("R8 pin", OK, 1, 0);
    steal("R2 steal lru", 8'd20, 8'd12, 2);
  endtask

  task automatic t_put_busy();
    cmd(PUT, 8'd10, 1'b0, 1'b0);
    exp_rsp("R7 put pinned", BUSY, 1, 0);
    exp_prog("R7 put pinned", 0, 0, 0);
    cmd(GET, 8'd10, 1'b1, 1'b0);
    exp_rsp("R7 still bound", OK, 1, 0);
  endtask

  task automatic t_all_pinned();
    cmd(PIN, 8'd20, 1'b0, 1'b0);
    cmd(PIN, 8'd11, 1'b0, 1'b0);
    cmd(PIN, 8'd13, 1'b0, 1'b0);
    exp_rsp("R8 pin d", OK, 1, 3);
    pend = 1'b1;
    cmd(GET, 8'd30, 1'b1, 1'b0);
    exp_rsp("R3 retry", RETRY, 0, 0);
    exp_prog("R3 retry", 0, 0, 0);
    chk("R3 retry no wait", int'(wait_req), 0);
    pend = 1'b0;
    cmd(GET, 8'd30, 1'b1, 1'b0);
    exp_rsp("R3 deadlock", DEADLOCK, 0, 0);
    chk("R3 deadlock no wait", int'(wait_req), 0);
  endtask

  task automatic t_unpin_zero();
    cmd(UNPIN, 8'd13, 1'b0, 1'b0);
    exp_rsp("R8 unpin", OK, 1, 3);
    cmd(UNPIN, 8'd13, 1'b0, 1'b0);
    exp_rsp("R8 unpin at zero", PINERR, 1, 3);
    steal("R8 count kept zero R2", 8'd31, 8'd13, 3);
  endtask

  task automatic t_put_free();
    cmd(PUT, 8'd31, 1'b0, 1'b0);
    exp_rsp("R7 put free", OK, 0, 0);
    exp_prog("R7 put free", 1, 0, 3);
    get_new("R7 slot reused R1", 8'd40, 3);
    cmd(PUT, 8'd99, 1'b0, 1'b0);
    exp_rsp("R7 put unbound", OK, 0, 0);
    exp_prog("R7 put unbound", 0, 0, 0);
  endtask

  task automatic t_untiled();
    cmd(GET, 8'd50, 1'b0, 1'b0);
    exp_rsp("R6 untiled", OK, 0, 0);
    exp_prog("R6 untiled", 0, 0, 0);
  endtask

  task automatic t_dirty();
    cmd(GET, 8'd40, 1'b1, 1'b1);
    exp_rsp("R5 dirty tiled", OK, 1, 3);
    exp_prog("R5 dirty tiled", 1, 1, 3);
    cmd(GET, 8'd40, 1'b0, 1'b1);
    exp_rsp("R5 dirty untiled", OK, 0, 0);
    exp_prog("R5 dirty untiled", 1, 0, 3);
    get_new("R5 released R1", 8'd41, 3);
  endtask

  task automatic t_pin_limits();
    cmd(PIN, 8'd77, 1'b0, 1'b0);
    exp_rsp("R8 pin unbound", OK, 0, 0);
    for (int i = 0; i < 15; i++) cmd(PIN, 8'd41, 1'b0, 1'b0);
    exp_rsp("R8 pin to max", OK, 1, 3);
    cmd(PIN, 8'd41, 1'b0, 1'b0);
    exp_rsp("R8 pin overflow", PINERR, 1, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_touch();
    t_steal_lru();
    t_put_busy();
    t_all_pinned();
    t_unpin_zero();
    t_put_free();
    t_untiled();
    t_dirty();
    t_pin_limits();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule